// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block translates every byte of an index word through a small table of bytes kept in local registers. The index word is split into independent 8-bit lanes, and each lane value is an unsigned byte address into the table. A lane whose address falls below a caller-supplied length limit returns the addressed table byte. Any other lane returns the byte in the same position of a caller-supplied fallback word. This lets a caller merge lookups into an existing value, rather than clearing the lanes that miss.

The table is filled through a synchronous write port that stores whole 64-bit words. With the default parameters the table holds four words, which is 32 bytes. Lookups are combinational from the stored contents. A build-time option adds a register on the result for timing-critical paths. The default is the combinational form, and the requirements below describe that form.

Top module: `byte_xlat_unit`

## Requirements
- R1: The index word is handled as four independent lanes. Lane k uses index bits [8k+7:8k] and produces result bits [8k+7:8k]. The value in one lane has no effect on any other lane.
- R2: A lane whose index is strictly below the effective limit outputs a table byte. Index bits [7:3] select the stored word and index bits [2:0] select the byte within it, where byte 0 is bits [7:0] of the word.
- R3: A lane whose index is greater than or equal to the effective limit outputs the byte of `fallback_word` at that lane's position.
- R4: At the boundary, index = limit-1 returns the table byte and index = limit returns the fallback byte. A limit of 0 sends every lane to the fallback.
- R5: The effective limit is the smaller of `lane_limit` and the table capacity of 32 bytes. Indices of 32 or more therefore always return the fallback byte, even when `lane_limit` is between 33 and 63.
- R6: On a rising edge with `wr_en`=1, `wr_data` is stored into word `wr_addr`. On a rising edge with `wr_en`=0, no stored word changes.
- R7: A rising edge with `rst`=1 clears all stored words to zero.
- R8: Lookups use the contents held before the current edge. A lookup in the same cycle as a write to the addressed word returns the old byte. From the cycle after that edge, the lookup returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes happen on the rising edge |
| rst | input | 1 | Synchronous reset that clears the table |
| wr_en | input | 1 | Write strobe for the table |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 64 | Word written into the table |
| index_word | input | 32 | Four byte indices, lane 0 in the low byte |
| fallback_word | input | 32 | Bytes used for lanes that miss the table |
| lane_limit | input | 6 | Number of valid table bytes for this lookup |
| result_word | output | 32 | Per-lane translated bytes |

## Verification
Each lookup result is due in the same cycle as its inputs, because no register lies on that path. The bench drives inputs on the falling edge and compares the result 3 ns later, well before the next rising edge. A table write takes effect at the rising edge that follows it, so the reference table in the bench is updated only after that edge. A lookup driven together with a write is therefore predicted from the old contents, and the next lookup is predicted from the new ones. Reset is checked the same way, after the edge at which it is sampled.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

   // Output timing variant of the lookup result
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

endpackage

// File: rtl/bxu_table_store.sv
module bxu_table_store #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 4,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [WORD_W-1:0]         wr_data,
   output logic [DEPTH*WORD_W-1:0]   tbl_flat
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bxu_table_store: DEPTH must be at least 2");
   end
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("bxu_table_store: DEPTH exceeds address range");
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              sel;

      assign sel = wr_en && (wr_addr == ADDR_W'(w));

      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (sel) begin
            word_q <= wr_data;
         end
      end

      assign tbl_flat[w*WORD_W +: WORD_W] = word_q;

      // R6: an addressed write lands in this word on the next edge
      assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
         (wr_en && wr_addr == ADDR_W'(w)) |=> (tbl_flat[w*WORD_W +: WORD_W] == $past(wr_data)));

      // R6: a word not addressed by an active write keeps its value
      assert_word_holds_R6: assert property (@(posedge clk) disable iff (rst)
         (!wr_en || wr_addr != ADDR_W'(w)) |=> $stable(tbl_flat[w*WORD_W +: WORD_W]));
   end

endmodule

// File: rtl/bxu_lane.sv
module bxu_lane #(
   parameter int LANE_W  = 8,
   parameter int WORD_W  = 64,
   parameter int DEPTH   = 4,
   parameter int LIMIT_W = 6,
   localparam int BPW    = WORD_W / LANE_W,
   localparam int SEL_W  = $clog2(BPW),
   localparam int WSEL_W = LANE_W - SEL_W,
   localparam int CMP_W  = LANE_W + LIMIT_W
) (
   input  logic [DEPTH*WORD_W-1:0] tbl_flat,
   input  logic [LANE_W-1:0]       idx,
   input  logic [LANE_W-1:0]       dflt,
   input  logic [LIMIT_W-1:0]      eff_limit,
   output logic [LANE_W-1:0]       res
);

   if ((1 << SEL_W) != BPW) begin : g_bad_bpw
      $error("bxu_lane: bytes per word must be a power of two");
   end
   if (DEPTH > (1 << WSEL_W)) begin : g_bad_depth
      $error("bxu_lane: lane index too narrow for table depth");
   end

   logic [WORD_W-1:0] word_pick;
   logic [LANE_W-1:0] byte_pick;
   logic              hit;

   // Word select from the upper index bits
   always_comb begin
      word_pick = '0;
      for (int w = 0; w < DEPTH; w++) begin
         if (idx[LANE_W-1:SEL_W] == WSEL_W'(w)) begin
            word_pick = tbl_flat[w*WORD_W +: WORD_W];
         end
      end
   end

   // Byte select from the lower index bits, byte 0 least significant
   always_comb begin
      byte_pick = '0;
      for (int b = 0; b < BPW; b++) begin
         if (idx[SEL_W-1:0] == SEL_W'(b)) begin
            byte_pick = word_pick[b*LANE_W +: LANE_W];
         end
      end
   end

   assign hit = CMP_W'(idx) < CMP_W'(eff_limit);
   assign res = hit ? byte_pick : dflt;

endmodule

// File: rtl/byte_xlat_unit.sv
module byte_xlat_unit #(
   parameter int                 LANES    = 4,
   parameter int                 LANE_W   = 8,
   parameter int                 WORD_W   = 64,
   parameter int                 DEPTH    = 4,
   parameter int                 LIMIT_W  = 6,
   parameter bxu_pkg::out_mode_e OUT_MODE = bxu_pkg::OUT_COMB,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IDX_W  = LANES * LANE_W,
   localparam int CAP    = DEPTH * (WORD_W / LANE_W),
   localparam int CMP_W  = LANE_W + LIMIT_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]   index_word,
   input  logic [IDX_W-1:0]   fallback_word,
   input  logic [LIMIT_W-1:0] lane_limit,
   output logic [IDX_W-1:0]   result_word
);

   if (WORD_W % LANE_W != 0) begin : g_bad_word
      $error("byte_xlat_unit: WORD_W must be a multiple of LANE_W");
   end
   if (CAP >= (1 << LIMIT_W)) begin : g_bad_limit
      $error("byte_xlat_unit: LIMIT_W cannot express table capacity");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("byte_xlat_unit: LANES must be positive");
   end

   logic [DEPTH*WORD_W-1:0] tbl_flat;
   logic [LIMIT_W-1:0]      eff_limit;
   logic [IDX_W-1:0]        lane_res;

   // Clamp the caller's limit to what the table can hold
   assign eff_limit = (lane_limit > LIMIT_W'(CAP)) ? LIMIT_W'(CAP) : lane_limit;

   bxu_table_store #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .tbl_flat (tbl_flat)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      bxu_lane #(
         .LANE_W  (LANE_W),
         .WORD_W  (WORD_W),
         .DEPTH   (DEPTH),
         .LIMIT_W (LIMIT_W)
      ) u_lane (
         .tbl_flat  (tbl_flat),
         .idx       (index_word[k*LANE_W +: LANE_W]),
         .dflt      (fallback_word[k*LANE_W +: LANE_W]),
         .eff_limit (eff_limit),
         .res       (lane_res[k*LANE_W +: LANE_W])
      );
   end

   if (OUT_MODE == bxu_pkg::OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            result_word <= '0;
         end else begin
            result_word <= lane_res;
         end
      end
   end else begin : g_out_comb
      assign result_word = lane_res;

      for (genvar k = 0; k < LANES; k++) begin : g_chk
         // R3: an index at or above the caller's limit yields the fallback byte
         assert_miss_fallback_R3: assert property (@(posedge clk) disable iff (rst)
            (CMP_W'(index_word[k*LANE_W +: LANE_W]) >= CMP_W'(lane_limit))
            |-> (result_word[k*LANE_W +: LANE_W] == fallback_word[k*LANE_W +: LANE_W]));

         // R5: an index past the table capacity never reads the table
         assert_past_capacity_R5: assert property (@(posedge clk) disable iff (rst)
            (int'(index_word[k*LANE_W +: LANE_W]) >= CAP)
            |-> (result_word[k*LANE_W +: LANE_W] == fallback_word[k*LANE_W +: LANE_W]));
      end
   end

endmodule

// File: tb/sim_byte_xlat_unit.sv
module sim_byte_xlat_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [63:0] wr_data;
   logic [31:0] index_word;
   logic [31:0] fallback_word;
   logic [5:0]  lane_limit;
   logic [31:0] result_word;

   always #5 clk = ~clk;

   byte_xlat_unit u0 (
      .clk           (clk),
      .rst           (rst),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .index_word    (index_word),
      .fallback_word (fallback_word),
      .lane_limit    (lane_limit),
      .result_word   (result_word)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t       sbq[$];
   logic [63:0] mdl[4];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;

   function automatic logic [31:0] predict(logic [31:0] idx, logic [31:0] dflt, int lim);
      logic [31:0] r;
      int eff;
      eff = (lim > 32) ? 32 : lim;
      for (int k = 0; k < 4; k++) begin
         int b;
         b = int'(idx[k*8 +: 8]);
         if (b < eff) r[k*8 +: 8] = mdl[b / 8][(b % 8) * 8 +: 8];
         else         r[k*8 +: 8] = dflt[k*8 +: 8];
      end
      return r;
   endfunction

   // Driver: apply a lookup and queue its expected result
   task automatic look(logic [31:0] idx, logic [31:0] dflt, int lim, string tag);
      item_t it;
      @(negedge clk);
      index_word    = idx;
      fallback_word = dflt;
      lane_limit    = 6'(lim);
      it.exp = predict(idx, dflt, lim);
      it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic write_word(bit en, logic [1:0] a, logic [63:0] d);
      @(negedge clk);
      wr_en   = en;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #1;
      if (en) mdl[a] = d;
      wr_en = 1'b0;
   endtask

   // Write and look up in the same cycle; expectation uses the old table
   task automatic write_and_look(logic [1:0] a, logic [63:0] d, logic [31:0] idx, int lim, string tag);
      item_t it;
      @(negedge clk);
      wr_en         = 1'b1;
      wr_addr       = a;
      wr_data       = d;
      index_word    = idx;
      fallback_word = 32'hDEAD_BEEF;
      lane_limit    = 6'(lim);
      it.exp = predict(idx, 32'hDEAD_BEEF, lim);
      it.tag = tag;
      sbq.push_back(it);
      @(posedge clk);
      #1;
      mdl[a] = d;
      wr_en  = 1'b0;
   endtask

   // Monitor: compare the result well inside the cycle the inputs were applied
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_chk++;
            if (result_word !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", it.tag, result_word, it.exp);
            end
         end
      end
   end

   initial begin
      #500us;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [7:0] pick_idx(int lim);
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
         0: return 8'(lim - 1);
         1: return 8'(lim);
         2: return 8'($urandom_range(0, 63));
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      rst = 1'b1;
      wr_en = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      index_word = '0;
      fallback_word = '0;
      lane_limit = '0;
      for (int w = 0; w < 4; w++) mdl[w] = '0;

      repeat (2) @(posedge clk);
      // R7: cleared table returns zero bytes for in-range lanes
      look({8'd31, 8'd17, 8'd9, 8'd0}, 32'hFFFF_FFFF, 32, "R7 reset clear");
      @(negedge clk);
      rst = 1'b0;

      for (int w = 0; w < 4; w++) begin
         logic [63:0] d;
         for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'((w * 8 + b) ^ 8'hA5);
         write_word(1'b1, 2'(w), d);
      end

      // R2: word/byte addressing
      look({8'd31, 8'd17, 8'd8, 8'd0}, 32'h1111_1111, 32, "R2 addressing");
      look({8'd7, 8'd26, 8'd12, 8'd5}, 32'h2222_2222, 32, "R2 addressing");
      // R1 and R3: mixed hits and misses across lanes
      look({8'd40, 8'd3, 8'd200, 8'd9}, 32'hC3C2_C1C0, 16, "R1,R3 mixed lanes");
      look({8'd2, 8'd255, 8'd15, 8'd16}, 32'h7766_5544, 16, "R1,R3 mixed lanes");
      // R4: boundaries
      look({8'd24, 8'd23, 8'd24, 8'd23}, 32'hABCD_EF01, 24, "R4 boundary 24");
      look({8'd255, 8'd0, 8'd8, 8'd7}, 32'h1234_5678, 8, "R4 boundary 8");
      look({8'd0, 8'd1, 8'd2, 8'd3}, 32'h9988_7766, 0, "R4 limit zero");
      // R5: limit above capacity
      look({8'd39, 8'd35, 8'd32, 8'd31}, 32'h5A5A_5A5A, 40, "R5 clamp 40");
      look({8'd62, 8'd33, 8'd0, 8'd31}, 32'hF0E1_D2C3, 63, "R5 clamp 63");

      // R6: a write with the strobe low changes nothing
      write_word(1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      look({8'd15, 8'd12, 8'd10, 8'd8}, 32'h0, 32, "R6 no write without strobe");
      // R6: a strobed write replaces only the addressed word
      write_word(1'b1, 2'd3, 64'h0102_0304_0506_0708);
      look({8'd31, 8'd24, 8'd23, 8'd8}, 32'h0, 32, "R6 write lands");

      // R8: same-cycle lookup sees the old word, the next one the new word
      write_and_look(2'd2, 64'h1F1E_1D1C_1B1A_1918, {8'd19, 8'd18, 8'd17, 8'd16}, 32, "R8 old contents");
      look({8'd19, 8'd18, 8'd17, 8'd16}, 32'h0, 32, "R8 new contents");

      // R2, R3, R4: random lookups around the legal limits
      for (int n = 0; n < 150; n++) begin
         int lim;
         logic [31:0] idx;
         lim = 8 * $urandom_range(1, 4);
         for (int k = 0; k < 4; k++) idx[k*8 +: 8] = pick_idx(lim);
         look(idx, $urandom(), lim, "R2,R3,R4 random");
      end

      // R7: reset in mid-run clears written contents
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      for (int w = 0; w < 4; w++) mdl[w] = '0;
      @(negedge clk);
      rst = 1'b0;
      look({8'd30, 8'd20, 8'd10, 8'd1}, 32'hFFFF_FFFF, 32, "R7 mid-run reset");

      @(negedge clk);
      #4;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule